// File: doc/BRIEF.md
# Four-Point Inverse DCT Butterfly

This block computes one dimension of a fixed-point 4-point inverse discrete cosine transform. Four signed 16-bit coefficients enter together with a strobe. One clock edge later, four signed 16-bit results leave with a matching strobe. The arithmetic is specified bit-exactly so that a decoder built around it matches a software codec sample for sample. The pre-additions wrap. Each 32-bit product term is rounded, shifted right by 14 and saturated. The final butterfly adds wrap.

The block has no transposition, no two-dimensional sequencing and no pixel reconstruction. A surrounding engine feeds it rows and then columns, and it adds the residual to the prediction. The three cosine weights are fixed in logic.

Top module: `idct4_butterfly`

## Requirements
- R1: The even part forms a = c0 + c2 and b = c0 - c2 as 16-bit two's-complement values that wrap without saturation. For example, 32767 + 1 gives -32768.
- R2: The even products are E0 = a * 11585 and E1 = b * 11585. 11585 is 0x2D41, the pi/4 weight. Each product is a full signed 32-bit value.
- R3: The odd products are O0 = c1 * 6270 - c3 * 15137 and O1 = c1 * 15137 + c3 * 6270, both signed 32-bit. 6270 is 0x187E and 15137 is 0x3B21.
- R4: Each of E0, E1, O0 and O1 is narrowed by adding 8192 and then shifting arithmetically right by 14. For example, a product of -8192 narrows to 0, and a product of 8192 narrows to 1.
- R5: A narrowed value above 32767 becomes 32767, and one below -32768 becomes -32768.
- R6: Let nE0, nE1, nO0 and nO1 be the narrowed values. The outputs are d0 = nE0 + nO1, d1 = nE1 + nO0, d2 = nE1 - nO0 and d3 = nE0 - nO1, each a wrapping 16-bit operation.
- R7: out_valid is high in the cycle after each clock edge at which in_valid was high, and low otherwise. The data of that transform appears in the same cycle.
- R8: While rst_n is low, out_valid is 0.
- R9: An edge at which in_valid is low leaves all four output data words unchanged.
- R10: When c1 = c3 = 0, d0 equals d3 and d1 equals d2. When c0 = c2 = 0, d0 + d3 and d1 + d2 are both 0 modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coefficient strobe |
| in_c0 | input | 16 | Coefficient 0, signed |
| in_c1 | input | 16 | Coefficient 1, signed |
| in_c2 | input | 16 | Coefficient 2, signed |
| in_c3 | input | 16 | Coefficient 3, signed |
| out_valid | output | 1 | Result strobe |
| out_d0 | output | 16 | Result 0, signed |
| out_d1 | output | 16 | Result 1, signed |
| out_d2 | output | 16 | Result 2, signed |
| out_d3 | output | 16 | Result 3, signed |

## Verification
The following are checked by properties on every clock:
- the one-cycle strobe latency;
- the strobe being held low in reset;
- the outputs holding still when no strobe arrives;
- the mirror symmetries that appear when only the even inputs or only the odd inputs are non-zero.

The bench compares every strobed result against an integer model. Only those comparisons can show that the weights, the rounding offset, the saturation and the wrap of the pre-additions are exact. Dedicated directed vectors drive the extremes -32768 and 32767 to reach those corners.

// File: rtl/idct4_butterfly.sv
module idct4_butterfly #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_c0,
  input  logic signed [W-1:0] in_c1,
  input  logic signed [W-1:0] in_c2,
  input  logic signed [W-1:0] in_c3,
  output logic                out_valid,
  output logic signed [W-1:0] out_d0,
  output logic signed [W-1:0] out_d1,
  output logic signed [W-1:0] out_d2,
  output logic signed [W-1:0] out_d3
);
  localparam int PW = 2 * W;

  localparam logic signed [W-1:0]  K_PI8  = W'(16'sh3B21);
  localparam logic signed [W-1:0]  K_PI4  = W'(16'sh2D41);
  localparam logic signed [W-1:0]  K_3PI8 = W'(16'sh187E);

  localparam logic signed [PW:0]   RND    = (PW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [PW:0]   SAT_HI = (PW+1)'((2 ** (W - 1)) - 1);
  localparam logic signed [PW:0]   SAT_LO = -SAT_HI - (PW+1)'(1);

  function automatic logic signed [W-1:0] narrow(input logic signed [PW-1:0] p);
    logic signed [PW:0] r;
    r = {p[PW-1], p} + RND;
    r = r >>> FRAC;
    if (r > SAT_HI)      narrow = SAT_HI[W-1:0];
    else if (r < SAT_LO) narrow = SAT_LO[W-1:0];
    else                 narrow = r[W-1:0];
  endfunction

  logic signed [W-1:0]  ev_sum, ev_dif;
  logic signed [PW-1:0] pe0, pe1, po0, po1;
  logic signed [W-1:0]  ne0, ne1, no0, no1;

  assign ev_sum = in_c0 + in_c2;
  assign ev_dif = in_c0 - in_c2;

  assign pe0 = PW'(ev_sum) * PW'(K_PI4);
  assign pe1 = PW'(ev_dif) * PW'(K_PI4);
  assign po0 = PW'(in_c1) * PW'(K_3PI8) - PW'(in_c3) * PW'(K_PI8);
  assign po1 = PW'(in_c1) * PW'(K_PI8)  + PW'(in_c3) * PW'(K_3PI8);

  assign ne0 = narrow(pe0);
  assign ne1 = narrow(pe1);
  assign no0 = narrow(po0);
  assign no1 = narrow(po1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_d0 <= ne0 + no1;
      out_d1 <= ne1 + no0;
      out_d2 <= ne1 - no0;
      out_d3 <= ne0 - no1;
    end
  end
endmodule

module idct4_butterfly_props #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic signed [W-1:0] in_c0,
  input logic signed [W-1:0] in_c1,
  input logic signed [W-1:0] in_c2,
  input logic signed [W-1:0] in_c3,
  input logic                out_valid,
  input logic signed [W-1:0] out_d0,
  input logic signed [W-1:0] out_d1,
  input logic signed [W-1:0] out_d2,
  input logic signed [W-1:0] out_d3
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    if (!rst_n) assert_reset_clear_R8: assert (!out_valid);
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |->
      ($stable(out_d0) && $stable(out_d1) && $stable(out_d2) && $stable(out_d3)));

  assert_even_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && $past(in_c1) == 0 && $past(in_c3) == 0) |->
      (out_d0 == out_d3 && out_d1 == out_d2));

  assert_odd_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && $past(in_c0) == 0 && $past(in_c2) == 0) |->
      (W'(out_d0 + out_d3) == W'(0) && W'(out_d1 + out_d2) == W'(0)));
endmodule

bind idct4_butterfly idct4_butterfly_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .in_c3(in_c3),
  .out_valid(out_valid),
  .out_d0(out_d0), .out_d1(out_d1), .out_d2(out_d2), .out_d3(out_d3)
);

// File: tb/idct4_butterfly_bench.sv
`timescale 1ns/1ps
module idct4_butterfly_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
  logic out_valid;
  logic signed [15:0] d0, d1, d2, d3;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idct4_butterfly u_idct4_butterfly (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_c0(c0), .in_c1(c1), .in_c2(c2), .in_c3(c3),
    .out_valid(out_valid),
    .out_d0(d0), .out_d1(d1), .out_d2(d2), .out_d3(d3)
  );

  function automatic int wrap16(input longint x);
    longint y;
    y = x & 64'hFFFF;
    if (y >= 32768) y = y - 65536;
    return int'(y);
  endfunction

  function automatic int shrink(input longint p);
    longint r;
    r = (p + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic void ref_model(input int a0, a1, a2, a3, output int o[4]);
    int ea, eb, n0, n1, m0, m1;
    ea = wrap16(a0 + a2);
    eb = wrap16(a0 - a2);
    n0 = shrink(longint'(ea) * 11585);
    n1 = shrink(longint'(eb) * 11585);
    m0 = shrink(longint'(a1) * 6270 - longint'(a3) * 15137);
    m1 = shrink(longint'(a1) * 15137 + longint'(a3) * 6270);
    o[0] = wrap16(n0 + m1);
    o[1] = wrap16(n1 + m0);
    o[2] = wrap16(n1 - m0);
    o[3] = wrap16(n0 - m1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int a0, a1, a2, a3, input string req);
    int o[4];
    ref_model(a0, a1, a2, a3, o);
    @(negedge clk);
    c0 = 16'(a0); c1 = 16'(a1); c2 = 16'(a2); c3 = 16'(a3);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R7 valid"}, int'(out_valid), 1);
    check({req, " d0"}, int'(d0), o[0]);
    check({req, " d1"}, int'(d1), o[1]);
    check({req, " d2"}, int'(d2), o[2]);
    check({req, " d3"}, int'(d3), o[3]);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s;
    int h0, h1, h2, h3;
    s = $urandom(32'h1D5C7);
    repeat (3) @(negedge clk);
    check("R8 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset valid", int'(out_valid), 0);

    apply(0, 0, 0, 0, "R6 zero");
    apply(64, 0, 0, 0, "R2 dc");
    apply(32767, 0, 1, 0, "R1 wrap sum");
    apply(-32768, 0, 1, 0, "R1 wrap dif");
    apply(-32768, 0, -32768, 0, "R1 wrap neg");
    apply(0, 1, 0, 0, "R4 round small");
    apply(0, 0, 0, 1, "R4 round odd");
    apply(0, -32768, 0, 32767, "R5 saturate low");
    apply(0, 32767, 0, -32768, "R5 saturate high");
    apply(0, 32767, 0, 32767, "R3 odd max");
    apply(32767, -32768, -32768, 32767, "R6 extremes");
    apply(-32768, -32768, -32768, -32768, "R6 all min");
    apply(100, 0, -300, 0, "R10 even only");
    apply(0, 1234, 0, -4321, "R10 odd only");

    h0 = d0; h1 = d1; h2 = d2; h3 = d3;
    @(negedge clk);
    c0 = 16'sd999; c1 = -16'sd7; c2 = 16'sd55; c3 = 16'sd2000;
    @(negedge clk);
    check("R9 hold valid", int'(out_valid), 0);
    check("R9 hold d0", int'(d0), h0);
    check("R9 hold d1", int'(d1), h1);
    check("R9 hold d2", int'(d2), h2);
    check("R9 hold d3", int'(d3), h3);

    for (int i = 0; i < 1500; i++) begin
      int r[4];
      for (int k = 0; k < 4; k++) begin
        case ($urandom % 4)
          0: r[k] = 32767;
          1: r[k] = -32768;
          2: r[k] = int'($urandom % 512) - 256;
          default: r[k] = int'($urandom % 65536) - 32768;
        endcase
      end
      apply(r[0], r[1], r[2], r[3], "R3 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule